// File: doc/BRIEF.md
# ESF Bit-Oriented Message Sender

This block puts a repeating 16-bit bit-oriented message on the facility data link of an extended-superframe T1 framer. The host loads a 6-bit message code and sets an enable bit. The block wraps the code in a fixed frame of ones and zeros to form a codeword. It then shifts the codeword out one bit for each data-link slot strobe that the framer supplies. While the block is disabled, the serial line idles at all ones.

The block counts complete codewords. When the tenth codeword has gone out, it sets a sticky completion flag. A second sticky flag records a transmit-stack-empty event, which another part of the framer reports. The host clears either flag by writing a 1 to it. Each flag has its own mask bit, and the interrupt output is raised by any flag that is set and not masked. When the host clears the enable bit, transmission stops at once, even in the middle of a codeword. A later enable starts over, both the codeword and the count of ten.

Top module: `esf_bom_tx`

## Requirements
- R1: The codeword, read from its most significant bit down, is 0, the code bits M5 down to M0, 0, and then eight 1s. It is sent least significant bit first, so each codeword goes out as eight 1s, a 0, M0 through M5, and a final 0. Code 111110 gives codeword 0111110011111111.
- R2: While enabled, `txd` presents the current codeword bit. The bit index advances only at a clock edge where `slot_stb` is 1, so `txd` changes only in the cycle after a strobe.
- R3: While the enable bit is 0, `txd` is 1 and strobes have no effect. A write that clears the enable makes `txd` 1 from the next cycle on.
- R4: Clearing the enable abandons both the current codeword and the count of ten. A 0-to-1 write of the enable starts at bit 0 of the codeword built from the code written in that same write, with the repetition count at zero.
- R5: The completion flag (status bit 1) is set at the strobe edge that finishes the tenth codeword after an enable. Codewords keep going out after that for as long as the enable stays 1.
- R6: A code written while the block is enabled takes effect only at the next codeword boundary. No codeword mixes old and new code bits.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a set event and a clear arrive in the same cycle, the set wins.
- R8: A one-cycle pulse on `stk_empty_evt` sets the stack-empty flag (status bit 0).
- R9: Both mask bits reset to 1. The mask register holds bit 1 for the completion flag and bit 0 for the stack-empty flag. `irq` is 1 exactly when some status bit is 1 and its mask bit is 0.
- R10: Register map: address 0 is control (bit 6 enable, bits 5:0 code), address 1 is status, address 2 is mask, and address 3 reads 0. Reserved bits read back as 0 whatever is written to them. `rd_data` follows `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 2 | Host read address |
| rd_data | output | 8 | Host read data |
| slot_stb | input | 1 | One-cycle data-link bit slot strobe from the framer |
| stk_empty_evt | input | 1 | Pulse reporting that the transmit stack is empty |
| txd | output | 1 | Serial data-link bit |
| irq | output | 1 | Interrupt request |

## Verification
The bench watches for a completion flag that rises after nine codewords or after eleven. That would show a count that is off by one, or one that carries over from an enable that was abandoned. It changes the code partway through a codeword, which catches a design that sends mixed bits or applies the new code late. It drops the enable in the middle of a codeword, which exposes a line that keeps sending instead of idling at ones, or a restart that does not begin at bit 0. It also raises a set event and a clear in the same cycle, and checks that a write of 0 leaves a set flag alone. A wrong design would lose the event or clear the flag.

// File: rtl/bom_pkg.sv
package bom_pkg;

    localparam int MSG_W   = 6;
    localparam int FILL_W  = 8;
    localparam int CW_W    = MSG_W + FILL_W + 2;
    localparam int REPS    = 10;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int NSTAT   = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_MASK = 2'd2;

    localparam int ST_EMPTY = 0;
    localparam int ST_DONE  = 1;

    typedef struct packed {
        logic             en;
        logic [MSG_W-1:0] code;
    } ctrl_t;

    typedef logic [NSTAT-1:0] flags_t;

    function automatic logic [CW_W-1:0] build_cw(input logic [MSG_W-1:0] m);
        return {1'b0, m, 1'b0, {FILL_W{1'b1}}};
    endfunction

endpackage

// File: rtl/bom_host_regs.sv
module bom_host_regs
    import bom_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    input  flags_t        status,
    output ctrl_t         ctrl,
    output flags_t        mask,
    output flags_t        clr,
    output logic          en_rise,
    output logic [MSG_W-1:0] rise_code,
    output logic [DW-1:0] rd_data
);
    localparam int CTRL_W = MSG_W + 1;

    logic  wr_ctrl, wr_stat, wr_mask;
    ctrl_t ctrl_in;
    logic  unused_bits;

    assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
    assign wr_stat   = wr_en && (wr_addr == A_STAT);
    assign wr_mask   = wr_en && (wr_addr == A_MASK);
    assign ctrl_in   = ctrl_t'(wr_data[CTRL_W-1:0]);
    assign en_rise   = wr_ctrl && ctrl_in.en && !ctrl.en;
    assign rise_code = ctrl_in.code;
    assign clr       = wr_stat ? wr_data[NSTAT-1:0] : '0;
    assign unused_bits = &{1'b0, wr_data[DW-1:CTRL_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            mask <= '1;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_in;
            if (wr_mask) mask <= wr_data[NSTAT-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data = DW'(ctrl);
            A_STAT:  rd_data = DW'(status);
            A_MASK:  rd_data = DW'(mask);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/bom_serializer.sv
module bom_serializer
    import bom_pkg::*;
#(
    parameter int MW   = MSG_W,
    parameter int NREP = REPS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          en_rise,
    input  logic [MW-1:0] rise_code,
    input  logic [MW-1:0] code,
    input  logic          slot_stb,
    output logic          txd,
    output logic          done_evt,
    output logic [$clog2(MW+FILL_W+2)-1:0] idx_o
);
    localparam int CWW   = MW + FILL_W + 2;
    localparam int IDX_W = $clog2(CWW);
    localparam int CNT_W = $clog2(NREP + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(CWW - 1);

    logic [CWW-1:0]   cw_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    function automatic logic [CWW-1:0] frame(input logic [MW-1:0] m);
        return {1'b0, m, 1'b0, {FILL_W{1'b1}}};
    endfunction

    assign wrap     = en && slot_stb && (idx_q == LAST);
    assign done_evt = wrap && (cnt_q == CNT_W'(NREP - 1));
    assign txd      = en ? cw_q[idx_q] : 1'b1;
    assign idx_o    = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cw_q  <= '1;
            idx_q <= '0;
            cnt_q <= '0;
        end else if (en_rise) begin
            cw_q  <= frame(rise_code);
            idx_q <= '0;
            cnt_q <= '0;
        end else if (!en) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else if (slot_stb) begin
            if (idx_q == LAST) begin
                idx_q <= '0;
                cw_q  <= frame(code);
                if (cnt_q != CNT_W'(NREP)) cnt_q <= cnt_q + 1'b1;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bom_status.sv
module bom_status
    import bom_pkg::*;
#(
    parameter int NS = NSTAT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NS-1:0] set_evt,
    input  logic [NS-1:0] clr,
    input  logic [NS-1:0] mask,
    output logic [NS-1:0] status,
    output logic          irq
);
    for (genvar i = 0; i < NS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             status[i] <= 1'b0;
            else if (set_evt[i]) status[i] <= 1'b1;
            else if (clr[i])     status[i] <= 1'b0;
        end
    end

    assign irq = |(status & ~mask);
endmodule

// File: rtl/esf_bom_tx.sv
module esf_bom_tx
    import bom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              slot_stb,
    input  logic              stk_empty_evt,
    output logic              txd,
    output logic              irq
);
    ctrl_t            ctrl;
    flags_t           mask, clr, status, set_evt;
    logic             en_rise, done_evt;
    logic [MSG_W-1:0] rise_code;
    logic [$clog2(CW_W)-1:0] bit_idx;

    bom_host_regs u_regs (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr,
        .status, .ctrl, .mask, .clr, .en_rise, .rise_code, .rd_data
    );

    bom_serializer u_ser (
        .clk, .rst,
        .en        (ctrl.en),
        .en_rise,
        .rise_code,
        .code      (ctrl.code),
        .slot_stb,
        .txd,
        .done_evt,
        .idx_o     (bit_idx)
    );

    always_comb begin
        set_evt           = '0;
        set_evt[ST_DONE]  = done_evt;
        set_evt[ST_EMPTY] = stk_empty_evt;
    end

    bom_status u_stat (
        .clk, .rst, .set_evt, .clr, .mask, .status, .irq
    );
endmodule

// File: rtl/esf_bom_tx_chk.sv
module esf_bom_tx_chk
    import bom_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              slot_stb,
    input logic              tx_en,
    input logic              txd,
    input logic              irq,
    input logic              done_evt,
    input logic [NSTAT-1:0]  status,
    input logic [NSTAT-1:0]  mask,
    input logic [$clog2(CW_W)-1:0] bit_idx
);
    a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> txd);

    a_r2_idx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $past(tx_en) && !$past(slot_stb)) |-> $stable(bit_idx));

    a_r5_done_on_event: assert property (@(posedge clk) disable iff (rst)
        $rose(status[ST_DONE]) |-> $past(done_evt));

    a_r7_clear_done: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && wr_addr == A_STAT && wr_data[ST_DONE] && !done_evt)
        |-> !status[ST_DONE]);

    a_r9_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en && wr_addr == A_MASK) |-> $stable(mask));

    a_r9_all_masked: assert property (@(posedge clk) disable iff (rst)
        (mask == '1) |-> !irq);
endmodule

bind esf_bom_tx esf_bom_tx_chk u_chk (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .slot_stb,
    .tx_en (ctrl.en), .txd, .irq, .done_evt,
    .status, .mask, .bit_idx
);

// File: tb/esf_bom_tx_bench.sv
module esf_bom_tx_bench;
    logic       clk = 0, rst = 1;
    logic       wr_en = 0, slot_stb = 0, stk_empty_evt = 0;
    logic [1:0] wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       txd, irq;

    int n_cmp = 0, n_bad = 0;

    esf_bom_tx u_esf_bom_tx (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
        .slot_stb, .stk_empty_evt, .txd, .irq
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] cw_of(input logic [5:0] m);
        return {1'b0, m, 1'b0, 8'hFF};
    endfunction

    function automatic bit bit_at(input logic [5:0] m, input int k);
        if (k < 8) return 1'b1;
        if (k == 8 || k == 15) return 1'b0;
        return m[k-9];
    endfunction

    // behavioural reference model
    bit       m_en = 0, m_done = 0, m_se = 0;
    bit [1:0] m_mask = 2'b11;
    bit [5:0] m_code = 0, m_cur = 0;
    int       m_idx = 0, m_cnt = 0;

    always @(posedge clk) begin
        bit devt;
        bit [1:0] clrd;
        devt = 0;
        if (rst) begin
            m_en = 0; m_done = 0; m_se = 0; m_mask = 2'b11;
            m_code = 0; m_idx = 0; m_cnt = 0;
        end else begin
            if (wr_en && wr_addr == 0 && wr_data[6] && !m_en) begin
                m_idx = 0; m_cnt = 0; m_cur = wr_data[5:0];
            end else if (!m_en) begin
                m_idx = 0; m_cnt = 0;
            end else if (slot_stb) begin
                if (m_idx == 15) begin
                    devt = (m_cnt == 9);
                    m_idx = 0;
                    m_cur = m_code;
                    if (m_cnt < 10) m_cnt++;
                end else m_idx++;
            end
            clrd = (wr_en && wr_addr == 1) ? wr_data[1:0] : 2'b00;
            if (devt) m_done = 1; else if (clrd[1]) m_done = 0;
            if (stk_empty_evt) m_se = 1; else if (clrd[0]) m_se = 0;
            if (wr_en && wr_addr == 0) begin
                m_en = wr_data[6]; m_code = wr_data[5:0];
            end
            if (wr_en && wr_addr == 2) m_mask = wr_data[1:0];
        end
        #2;
        begin
            bit e_txd, e_irq;
            logic [7:0] e_rd;
            e_txd = m_en ? bit_at(m_cur, m_idx) : 1'b1;
            e_irq = (m_done && !m_mask[1]) || (m_se && !m_mask[0]);
            case (rd_addr)
                2'd0: e_rd = {1'b0, m_en, m_code};
                2'd1: e_rd = {6'b0, m_done, m_se};
                2'd2: e_rd = {6'b0, m_mask};
                default: e_rd = 8'h00;
            endcase
            check(txd === e_txd, "R2 txd", txd, e_txd);
            check(irq === e_irq, "R9 irq", irq, e_irq);
            check(rd_data === e_rd, "R10 rd_data", rd_data, e_rd);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic strobe(output bit b);
        @(negedge clk);
        b = txd;
        slot_stb = 1;
        @(negedge clk);
        slot_stb = 0;
    endtask

    task automatic nbits(input int n, output logic [15:0] w);
        w = '1;
        for (int k = 0; k < n; k++) begin
            bit b;
            strobe(b);
            w[k] = b;
            if (k % 5 == 2) @(negedge clk);
        end
    endtask

    task automatic words(input int n);
        logic [15:0] w;
        for (int i = 0; i < n; i++) nbits(16, w);
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  r;
        logic [15:0] w, w2;
        repeat (3) @(negedge clk);
        rst = 0;

        // reset state
        rdreg(2, r); check(r == 8'h03, "R9 mask reset", r, 8'h03);
        rdreg(1, r); check(r == 8'h00, "R10 status reset", r, 8'h00);
        check(txd == 1'b1, "R3 idle after reset", txd, 1);
        begin
            bit b;
            strobe(b); check(b == 1'b1, "R3 strobe while disabled", b, 1);
        end

        // first codeword, code 111110
        wr(0, 8'h7E);
        nbits(16, w);
        check(w == 16'b0111110011111111, "R1 codeword order", w, 16'b0111110011111111);
        words(8);
        rdreg(1, r); check(r[1] == 1'b0, "R5 not done after nine", r[1], 0);
        nbits(16, w);
        rdreg(1, r); check(r[1] == 1'b1, "R5 done after ten", r[1], 1);
        check(irq == 1'b0, "R9 masked irq", irq, 0);
        wr(2, 8'h01);
        check(irq == 1'b1, "R9 unmasked irq", irq, 1);
        nbits(16, w);
        check(w == cw_of(6'h3E), "R5 continues after ten", w, cw_of(6'h3E));

        // code change mid-word, reserved bit set
        nbits(5, w);
        wr(0, 8'hC1);
        nbits(11, w2);
        w = {w2[10:0], w[4:0]};
        check(w == cw_of(6'h3E), "R6 old word finishes", w, cw_of(6'h3E));
        nbits(16, w);
        check(w == cw_of(6'h01), "R6 new code at boundary", w, cw_of(6'h01));
        rdreg(0, r); check(r == 8'h41, "R10 reserved reads zero", r, 8'h41);

        // status clear-on-write, stack-empty flag
        wr(1, 8'h02);
        rdreg(1, r); check(r[1] == 1'b0, "R7 done cleared", r[1], 0);
        @(negedge clk); stk_empty_evt = 1; @(negedge clk); stk_empty_evt = 0;
        rdreg(1, r); check(r[0] == 1'b1, "R8 stack empty set", r[0], 1);
        check(irq == 1'b0, "R9 stack empty masked", irq, 0);
        wr(2, 8'h00);
        check(irq == 1'b1, "R9 stack empty irq", irq, 1);
        wr(1, 8'h00);
        rdreg(1, r); check(r[0] == 1'b1, "R7 write zero keeps", r[0], 1);
        wr(1, 8'h01);
        rdreg(1, r); check(r[0] == 1'b0, "R7 write one clears", r[0], 0);
        @(negedge clk);
        stk_empty_evt = 1; wr_en = 1; wr_addr = 1; wr_data = 8'h01;
        @(negedge clk);
        stk_empty_evt = 0; wr_en = 0;
        rdreg(1, r); check(r[0] == 1'b1, "R7 set wins", r[0], 1);
        wr(1, 8'h01);
        wr(2, 8'h01);

        // stop mid-word and restart
        wr(0, 8'h7E);
        nbits(16, w);
        nbits(7, w);
        wr(0, 8'h3E);
        check(txd == 1'b1, "R3 idle after disable", txd, 1);
        nbits(3, w);
        check(w[2:0] == 3'b111, "R4 no bits while off", w[2:0], 3'b111);
        wr(0, 8'h7E);
        nbits(16, w);
        check(w == cw_of(6'h3E), "R4 restart at bit zero", w, cw_of(6'h3E));
        words(8);
        nbits(4, w);
        wr(0, 8'h3E);
        wr(0, 8'h7E);
        words(9);
        rdreg(1, r); check(r[1] == 1'b0, "R4 count restarted", r[1], 0);
        words(1);
        rdreg(1, r); check(r[1] == 1'b1, "R5 done after fresh ten", r[1], 1);
        check(irq == 1'b1, "R9 done irq", irq, 1);

        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule